// File: doc/BRIEF.md
# I2C Master Burst Transmitter

This block is a single-master I2C transmitter. Software programs a bit-rate divider, loads up to 32 bytes into a word-addressed buffer (the byte holding the 7-bit target address and the R/W bit is the least significant byte of the first word), requests a start condition, and then writes the byte count. That one count write sends the whole burst, most significant bit first. Each byte takes nine SCL periods, and the ninth is the acknowledge slot. When every byte has been acknowledged, one completion flag is raised. A not-acknowledge ends the burst early and raises its own flag. A stop condition is requested separately.

Both bus lines are open-drain. The block pulls a line low by raising its output enable and never drives it high, and it reads SDA back to sample the acknowledge. Four events (start produced, stop produced, burst finished, NAK received) set sticky pending bits. These are cleared by writing ones, and each one can be routed to the single interrupt output by its enable bit.

Top module: `i2c_burst_tx`

## Requirements
- R1: After a synchronous active-low reset, both line enables are low, `irq` is low, and every register, buffer word included, reads 0.
- R2: The divider register (offset 1) holds L in bits 15:0 and H in bits 31:16. During a byte, every SCL low phase lasts 8*(L+1) clocks and every SCL high phase lasts 8*(H+1) clocks.
- R3: Control (offset 0) has bit 0 enable, bits 2:1 mode (0 = transmit), bit 3 start and bit 4 stop. A control write with bits 0 and 3 set, made while the block is already enabled and idle, produces a start condition (SDA falls while SCL is high), then holds SCL low and sets pending bit 4. In any other case the start request is ignored.
- R4: A control write with bits 0 and 4 set (bit 3 clear), made while the block is enabled and idle, drives SDA low during an SCL low phase, releases SCL, and after one high phase releases SDA. It then sets pending bit 5, and both lines end up released.
- R5: Writing N (1..32) to the count register (offset 2, bits 5:0) sends N bytes, MSB first. Byte k comes from buffer word k/4 (offset 8 + k/4), bits 8*(k%4)+7 down to 8*(k%4).
- R6: Within a byte, SDA changes only while SCL is low, one clock after SCL falls, so no start or stop appears inside a burst.
- R7: The acknowledge is sampled at the middle of the ninth high phase. When the last byte is acknowledged, pending bit 2 is set, SCL is held low and SDA is released.
- R8: On a NAK, pending bit 6 is set, no further byte is sent, and pending bit 2 stays clear.
- R9: A count write of 0 or above 32 is ignored, and so is one made while a burst or condition is in progress, while disabled, or with a mode other than 0.
- R10: The pending register (offset 4) is write-one-to-clear. A bit stays set until a 1 is written to it.
- R11: `irq` is high exactly when some pending bit and its enable bit (offset 3, same position) are both 1.
- R12: Clearing the enable bit returns the engine to idle on the next clock and releases both lines. A burst cut short this way sets no completion flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | SDA line level |
| irq | output | 1 | Interrupt, OR of enabled pending bits |

## Verification
Bursts of 3, 32 and 6 bytes are sent under two divider settings, each with a distinct byte pattern. The decoded bytes show the little-endian byte order, and the measured phase lengths show whether the low and high dividers are applied separately. One burst is sent to a target that NAKs its third byte, which separates the early-abort path from normal completion. Count writes of 0, 33, while busy and in a non-transmit mode are each followed by a quiet window to show they are ignored. A disable in mid-byte checks that the lines are released and that no completion is reported.

// File: rtl/i2c_burst_tx_pkg.sv
// Package: shared register offsets, pending bit positions and engine states
// for the I2C burst transmitter. Assumes word addressing on the register port.
package i2c_burst_tx_pkg;
    localparam int OFS_CTRL = 0;
    localparam int OFS_DIV  = 1;
    localparam int OFS_CNT  = 2;
    localparam int OFS_IEN  = 3;
    localparam int OFS_PEND = 4;

    localparam int PB_DONE  = 2;
    localparam int PB_START = 4;
    localparam int PB_STOP  = 5;
    localparam int PB_NAK   = 6;
    localparam int PEND_W   = 7;

    typedef enum logic [2:0] {
        EN_IDLE,   // waiting for a request
        EN_SREL,   // start: release SDA during a low phase
        EN_SHI1,   // start: SCL high, SDA high
        EN_SHI2,   // start: SCL high, SDA low
        EN_BLOW,   // bit: SCL low, SDA updated
        EN_BHIGH,  // bit: SCL high, SDA stable
        EN_PLOW,   // stop: SCL low, SDA pulled low
        EN_PHIGH   // stop: SCL high before SDA release
    } eng_state_t;
endpackage

// File: rtl/i2c_burst_tx_regs.sv
// Register block: control, divider, count, interrupt enable, W1C pending and
// the transmit buffer. Produces one-cycle requests for the engine. Assumes
// NUM_WORDS >= 8 so control offsets sit below the buffer window.
module i2c_burst_tx_regs
    import i2c_burst_tx_pkg::*;
#(
    parameter int NUM_WORDS = 8,
    parameter int DIVW      = 16,
    localparam int AW   = $clog2(NUM_WORDS) + 1,
    localparam int WIW  = $clog2(NUM_WORDS),
    localparam int MAXB = NUM_WORDS * 4,
    localparam int BIW  = $clog2(MAXB),
    localparam int CNTW = BIW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_we,
    input  logic [AW-1:0]   reg_addr,
    input  logic [31:0]     reg_wdata,
    output logic [31:0]     reg_rdata,
    input  logic            busy,
    input  logic            ev_start,
    input  logic            ev_stop,
    input  logic            ev_done,
    input  logic            ev_nak,
    input  logic [BIW-1:0]  byte_idx,
    output logic            en,
    output logic [DIVW-1:0] div_lo,
    output logic [DIVW-1:0] div_hi,
    output logic            go_start,
    output logic            go_stop,
    output logic            go_burst,
    output logic [CNTW-1:0] burst_len,
    output logic [7:0]      tx_byte,
    output logic            irq
);
    logic [4:0]        ctrl_q;
    logic [2*DIVW-1:0] div_q;
    logic [CNTW-1:0]   cnt_q;
    logic [PEND_W-1:0] ien_q;
    logic [PEND_W-1:0] pend_q;
    logic [31:0]       buf_q [NUM_WORDS];
    logic [PEND_W-1:0] ev_vec;
    logic              wr_ctrl, wr_cnt, wr_pend, cnt_ok;

    assign wr_ctrl = reg_we && (reg_addr == AW'(OFS_CTRL));
    assign wr_cnt  = reg_we && (reg_addr == AW'(OFS_CNT));
    assign wr_pend = reg_we && (reg_addr == AW'(OFS_PEND));
    assign cnt_ok  = (reg_wdata[CNTW-1:0] != '0) && (reg_wdata[CNTW-1:0] <= CNTW'(MAXB));

    // Requests reach the engine only when it is already enabled and idle.
    assign go_start = wr_ctrl && ctrl_q[0] && reg_wdata[0] && reg_wdata[3] && !busy;
    assign go_stop  = wr_ctrl && ctrl_q[0] && reg_wdata[0] && reg_wdata[4] && !reg_wdata[3] && !busy;
    assign go_burst = wr_cnt && ctrl_q[0] && (ctrl_q[2:1] == 2'd0) && cnt_ok && !busy;

    assign en        = ctrl_q[0];
    assign div_lo    = div_q[DIVW-1:0];
    assign div_hi    = div_q[2*DIVW-1:DIVW];
    assign burst_len = cnt_q;
    assign tx_byte   = buf_q[byte_idx[BIW-1:2]][{byte_idx[1:0], 3'b000} +: 8];
    assign irq       = |(pend_q & ien_q);

    always_comb begin
        ev_vec = '0;
        ev_vec[PB_DONE]  = ev_done;
        ev_vec[PB_START] = ev_start;
        ev_vec[PB_STOP]  = ev_stop;
        ev_vec[PB_NAK]   = ev_nak;
    end

    // Control-side registers: control, divider, accepted count, enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            div_q  <= '0;
            cnt_q  <= '0;
            ien_q  <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= reg_wdata[4:0];
            if (reg_we && reg_addr == AW'(OFS_DIV)) div_q <= reg_wdata[2*DIVW-1:0];
            if (go_burst) cnt_q <= reg_wdata[CNTW-1:0];
            if (reg_we && reg_addr == AW'(OFS_IEN)) ien_q <= reg_wdata[PEND_W-1:0];
        end
    end

    // Pending flags: set by engine events, cleared by writing ones.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~(wr_pend ? reg_wdata[PEND_W-1:0] : '0)) | ev_vec;
    end

    // Transmit buffer, one register per word.
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n) buf_q[w] <= '0;
            else if (reg_we && reg_addr[AW-1] && reg_addr[WIW-1:0] == WIW'(w)) buf_q[w] <= reg_wdata;
        end
    end

    // Read multiplexer.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr[AW-1]) reg_rdata = buf_q[reg_addr[WIW-1:0]];
        else begin
            case (int'(reg_addr))
                OFS_CTRL: reg_rdata = 32'(ctrl_q);
                OFS_DIV:  reg_rdata = 32'(div_q);
                OFS_CNT:  reg_rdata = 32'(cnt_q);
                OFS_IEN:  reg_rdata = 32'(ien_q);
                OFS_PEND: reg_rdata = 32'(pend_q);
                default:  reg_rdata = '0;
            endcase
        end
    end

    a_r10_pend_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_pend |=> ((pend_q & $past(pend_q)) == $past(pend_q)));
    a_r9_launch_idle: assert property (@(posedge clk) disable iff (!rst_n)
        go_burst |=> busy);
endmodule

// File: rtl/i2c_burst_tx_engine.sv
// Bit engine: sequences start, byte bursts with acknowledge slots, and stop on
// open-drain SCL/SDA enables. Phase lengths come from the divider halves.
// Assumes a single master and no clock stretching by the target.
module i2c_burst_tx_engine
    import i2c_burst_tx_pkg::*;
#(
    parameter int DIVW = 16,
    parameter int MAXB = 32,
    localparam int BIW  = $clog2(MAXB),
    localparam int CNTW = BIW + 1,
    localparam int TW   = DIVW + 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [DIVW-1:0] div_lo,
    input  logic [DIVW-1:0] div_hi,
    input  logic            go_start,
    input  logic            go_stop,
    input  logic            go_burst,
    input  logic [CNTW-1:0] burst_len,
    input  logic [7:0]      tx_byte,
    output logic [BIW-1:0]  byte_idx,
    input  logic            sda_in,
    output logic            scl_oe,
    output logic            sda_oe,
    output logic            ev_start,
    output logic            ev_stop,
    output logic            ev_done,
    output logic            ev_nak,
    output logic            busy
);
    eng_state_t     state;
    logic [TW-1:0]  tmr;
    logic [TW-1:0]  low_m1, high_m1, half_m1;
    logic [3:0]     bit_cnt;
    logic [BIW-1:0] byte_cnt;
    logic           nak_q, last_byte;

    assign low_m1    = (TW'(div_lo) + TW'(1)) * TW'(8) - TW'(1);
    assign high_m1   = (TW'(div_hi) + TW'(1)) * TW'(8) - TW'(1);
    assign half_m1   = (TW'(div_hi) + TW'(1)) * TW'(4) - TW'(1);
    assign last_byte = (byte_cnt == BIW'(burst_len - CNTW'(1)));
    assign byte_idx  = byte_cnt;
    assign busy      = (state != EN_IDLE);

    // Main sequencer: phase timer, line enables, bit/byte counters, events.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            state    <= EN_IDLE;
            tmr      <= '0;
            scl_oe   <= 1'b0;
            sda_oe   <= 1'b0;
            bit_cnt  <= '0;
            byte_cnt <= '0;
            nak_q    <= 1'b0;
            ev_start <= 1'b0;
            ev_stop  <= 1'b0;
            ev_done  <= 1'b0;
            ev_nak   <= 1'b0;
        end else begin
            ev_start <= 1'b0;
            ev_stop  <= 1'b0;
            ev_done  <= 1'b0;
            ev_nak   <= 1'b0;
            if (tmr != '0) tmr <= tmr - TW'(1);
            case (state)
                EN_IDLE: begin
                    if (go_start) begin
                        sda_oe <= 1'b0;
                        tmr    <= low_m1;
                        state  <= EN_SREL;
                    end else if (go_stop) begin
                        scl_oe <= 1'b1;
                        tmr    <= low_m1;
                        state  <= EN_PLOW;
                    end else if (go_burst) begin
                        scl_oe   <= 1'b1;
                        bit_cnt  <= '0;
                        byte_cnt <= '0;
                        tmr      <= low_m1;
                        state    <= EN_BLOW;
                    end
                end
                EN_SREL: if (tmr == '0) begin
                    scl_oe <= 1'b0;
                    tmr    <= half_m1;
                    state  <= EN_SHI1;
                end
                EN_SHI1: if (tmr == '0) begin
                    sda_oe <= 1'b1;
                    tmr    <= half_m1;
                    state  <= EN_SHI2;
                end
                EN_SHI2: if (tmr == '0) begin
                    scl_oe   <= 1'b1;
                    ev_start <= 1'b1;
                    state    <= EN_IDLE;
                end
                EN_BLOW: begin
                    if (tmr == low_m1)
                        sda_oe <= (bit_cnt == 4'd8) ? 1'b0 : ~tx_byte[3'd7 - bit_cnt[2:0]];
                    if (tmr == '0) begin
                        scl_oe <= 1'b0;
                        tmr    <= high_m1;
                        state  <= EN_BHIGH;
                    end
                end
                EN_BHIGH: begin
                    if (bit_cnt == 4'd8 && tmr == half_m1) nak_q <= sda_in;
                    if (tmr == '0) begin
                        scl_oe <= 1'b1;
                        tmr    <= low_m1;
                        if (bit_cnt != 4'd8) begin
                            bit_cnt <= bit_cnt + 4'd1;
                            state   <= EN_BLOW;
                        end else if (nak_q) begin
                            ev_nak <= 1'b1;
                            state  <= EN_IDLE;
                        end else if (last_byte) begin
                            ev_done <= 1'b1;
                            state   <= EN_IDLE;
                        end else begin
                            byte_cnt <= byte_cnt + BIW'(1);
                            bit_cnt  <= '0;
                            state    <= EN_BLOW;
                        end
                    end
                end
                EN_PLOW: begin
                    if (tmr == low_m1) sda_oe <= 1'b1;
                    if (tmr == '0) begin
                        scl_oe <= 1'b0;
                        tmr    <= high_m1;
                        state  <= EN_PHIGH;
                    end
                end
                EN_PHIGH: if (tmr == '0) begin
                    sda_oe  <= 1'b0;
                    ev_stop <= 1'b1;
                    state   <= EN_IDLE;
                end
                default: state <= EN_IDLE;
            endcase
        end
    end

    a_r6_sda_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
        (state == EN_BHIGH && $past(state) == EN_BHIGH) |-> $stable(sda_oe));
    a_r12_release_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!scl_oe && !sda_oe));
    a_r7_done_lines: assert property (@(posedge clk) disable iff (!rst_n)
        ev_done |-> (scl_oe && !sda_oe));
    a_r8_single_event: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_start, ev_stop, ev_done, ev_nak}));
endmodule

// File: rtl/i2c_burst_tx.sv
// Top: I2C master burst transmitter. Joins the register block and the bit
// engine. Assumes open-drain pads with external pull-ups on SCL and SDA.
module i2c_burst_tx
    import i2c_burst_tx_pkg::*;
#(
    parameter int NUM_WORDS = 8,
    parameter int DIVW      = 16,
    localparam int AW   = $clog2(NUM_WORDS) + 1,
    localparam int MAXB = NUM_WORDS * 4,
    localparam int BIW  = $clog2(MAXB),
    localparam int CNTW = BIW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [AW-1:0] reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          scl_oe,
    output logic          sda_oe,
    input  logic          sda_in,
    output logic          irq
);
    logic            en, go_start, go_stop, go_burst, busy;
    logic            ev_start, ev_stop, ev_done, ev_nak;
    logic [DIVW-1:0] div_lo, div_hi;
    logic [CNTW-1:0] burst_len;
    logic [7:0]      tx_byte;
    logic [BIW-1:0]  byte_idx;

    i2c_burst_tx_regs #(.NUM_WORDS(NUM_WORDS), .DIVW(DIVW)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
        .ev_start(ev_start), .ev_stop(ev_stop), .ev_done(ev_done), .ev_nak(ev_nak),
        .byte_idx(byte_idx), .en(en), .div_lo(div_lo), .div_hi(div_hi),
        .go_start(go_start), .go_stop(go_stop), .go_burst(go_burst),
        .burst_len(burst_len), .tx_byte(tx_byte), .irq(irq)
    );

    i2c_burst_tx_engine #(.DIVW(DIVW), .MAXB(MAXB)) u_engine (
        .clk(clk), .rst_n(rst_n), .en(en), .div_lo(div_lo), .div_hi(div_hi),
        .go_start(go_start), .go_stop(go_stop), .go_burst(go_burst),
        .burst_len(burst_len), .tx_byte(tx_byte), .byte_idx(byte_idx),
        .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .ev_start(ev_start), .ev_stop(ev_stop), .ev_done(ev_done), .ev_nak(ev_nak),
        .busy(busy)
    );
endmodule

// File: tb/tb_i2c_burst_tx.sv
// Bench: a behavioural I2C target watches the bus every clock, decodes start,
// stop and bytes, compares bytes against a queue of expected values, measures
// SCL phase lengths and answers ACK or NAK.
module tb_i2c_burst_tx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        scl_oe, sda_oe, sda_in, irq;
    logic        tgt_pull = 1'b0;

    int total = 0, bad = 0;
    int starts = 0, stops = 0, rx_cnt = 0, nak_at = -1;
    int exp_low = 8, exp_high = 8;
    bit mon_off = 1'b0;
    logic [7:0] exp_q [$];

    always #4 clk = ~clk;
    assign sda_in = ~(sda_oe | tgt_pull);

    i2c_burst_tx dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_oe(scl_oe),
        .sda_oe(sda_oe), .sda_in(sda_in), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [7:0] pat(input int k);
        return 8'((k * 37 + 11) & 255);
    endfunction

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = 4'(a);
        #1 d = reg_rdata;
    endtask

    task automatic wait_pend(input int b, input string req);
        logic [31:0] v = '0;
        for (int i = 0; i < 20000; i++) begin
            rd(4, v);
            if (v[b]) break;
        end
        chk(req, 32'(v[b]), 32'd1);
    endtask

    // Load n bytes starting at pattern index base; queue the first nexp.
    task automatic load(input int n, input int base, input int nexp);
        for (int w = 0; w < (n + 3) / 4; w++)
            wr(8 + w, {pat(base + 4*w + 3), pat(base + 4*w + 2), pat(base + 4*w + 1), pat(base + 4*w)});
        for (int k = 0; k < nexp; k++) exp_q.push_back(pat(base + k));
    endtask

    // Target model sampled every clock at the falling edge.
    logic prev_scl = 1'b1, prev_sda = 1'b1;
    int bitcnt = 0, phase_len = 1;
    logic [7:0] shreg = '0;
    always @(negedge clk) begin
        logic scl_now, sda_now;
        scl_now = ~scl_oe;
        sda_now = sda_in;
        if (!rst_n || mon_off) begin
            bitcnt = 0; tgt_pull = 1'b0; phase_len = 1;
        end else begin
            if (scl_now == prev_scl) phase_len++;
            if (scl_now && !prev_scl) begin
                if (bitcnt >= 1 && bitcnt <= 8) chk("R2 low phase", phase_len, exp_low);
                if (bitcnt < 8) shreg = {shreg[6:0], sda_now};
                bitcnt++;
                phase_len = 1;
            end else if (!scl_now && prev_scl) begin
                if (bitcnt >= 1) chk("R2 high phase", phase_len, exp_high);
                if (bitcnt == 8) begin
                    if (exp_q.size() == 0) chk("R5 unexpected byte", 32'(shreg), 32'hFFFF_FFFF);
                    else chk("R5 byte value", 32'(shreg), 32'(exp_q.pop_front()));
                    tgt_pull = (rx_cnt != nak_at);
                    rx_cnt++;
                end else if (bitcnt == 9) begin
                    tgt_pull = 1'b0;
                    bitcnt = 0;
                end
                phase_len = 1;
            end
            if (scl_now && prev_scl && sda_now != prev_sda) begin
                if (!sda_now) starts++; else stops++;
                bitcnt = 0;
            end
        end
        prev_scl = scl_now;
        prev_sda = sda_now;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int base_rx;
        repeat (4) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 scl_oe", 32'(scl_oe), 0);
        chk("R1 sda_oe", 32'(sda_oe), 0);
        chk("R1 irq", 32'(irq), 0);
        rd(0, v); chk("R1 ctrl", v, 0);
        rd(1, v); chk("R1 div", v, 0);
        rd(4, v); chk("R1 pend", v, 0);
        rd(8, v); chk("R1 buffer", v, 0);

        // R3 start while disabled-to-enabled in one write is ignored
        wr(0, 32'h9);
        repeat (100) @(negedge clk);
        rd(4, v); chk("R3 start ignored when not yet enabled", v, 0);
        chk("R3 no start on bus", starts, 0);
        wr(0, 32'h1);

        // R3 start, R11 irq, R10 W1C
        wr(3, 32'h74);
        wr(0, 32'h9);
        wait_pend(4, "R3 start pending");
        chk("R3 start seen", starts, 1);
        chk("R3 scl held low", 32'(scl_oe), 1);
        chk("R11 irq on enabled pending", 32'(irq), 1);
        wr(0, 32'h1);
        wr(4, 32'h10);
        rd(4, v); chk("R10 pending cleared", v, 0);
        chk("R11 irq low after clear", 32'(irq), 0);

        // R5 three-byte burst, R9 busy count write ignored, R7 completion
        load(3, 0, 3);
        wr(2, 32'd3);
        wr(2, 32'd5);
        wait_pend(2, "R7 done pending");
        chk("R5 three bytes", rx_cnt, 3);
        rd(4, v); chk("R8 no nak on full ack", v, 32'h4);
        chk("R7 scl held low", 32'(scl_oe), 1);
        chk("R7 sda released", 32'(sda_oe), 0);
        repeat (400) @(negedge clk);
        chk("R9 busy count write ignored", rx_cnt, 3);
        wr(4, 32'h4);

        // R4 stop
        wr(0, 32'h11);
        wait_pend(5, "R4 stop pending");
        chk("R4 stop seen", stops, 1);
        chk("R4 scl released", 32'(scl_oe), 0);
        chk("R4 sda released", 32'(sda_oe), 0);
        wr(4, 32'h20);
        wr(0, 32'h1);

        // R9 out-of-range counts and wrong mode
        wr(2, 32'd0);
        wr(2, 32'd33);
        wr(0, 32'h3);
        wr(2, 32'd2);
        repeat (300) @(negedge clk);
        chk("R9 ignored counts send nothing", rx_cnt, 3);
        rd(4, v); chk("R9 no pending from ignored counts", v, 0);
        chk("R9 lines idle", 32'(scl_oe | sda_oe), 0);
        wr(0, 32'h1);

        // R2 new divider, R5 full 32-byte burst
        wr(1, (32'd2 << 16) | 32'd1);
        exp_low = 16; exp_high = 24;
        wr(0, 32'h9);
        wait_pend(4, "R3 start pending 2");
        wr(0, 32'h1);
        wr(4, 32'h10);
        base_rx = rx_cnt;
        load(32, 100, 32);
        wr(2, 32'd32);
        wait_pend(2, "R7 done pending 32");
        chk("R5 thirty-two bytes", rx_cnt - base_rx, 32);
        wr(4, 32'h4);

        // R8 NAK on third byte
        wr(1, 32'd0);
        exp_low = 8; exp_high = 8;
        wr(0, 32'h9);
        wait_pend(4, "R3 repeated start pending");
        wr(0, 32'h1);
        wr(4, 32'h10);
        base_rx = rx_cnt;
        nak_at = rx_cnt + 2;
        load(6, 200, 3);
        wr(2, 32'd6);
        wait_pend(6, "R8 nak pending");
        chk("R8 bytes up to nak", rx_cnt - base_rx, 3);
        repeat (500) @(negedge clk);
        chk("R8 nothing after nak", rx_cnt - base_rx, 3);
        rd(4, v); chk("R8 nak without done", v & 32'h44, 32'h40);
        nak_at = -1;
        wr(4, 32'h40);
        wr(0, 32'h11);
        wait_pend(5, "R4 stop pending 2");
        chk("R4 stop seen 2", stops, 2);
        wr(4, 32'h20);
        wr(0, 32'h1);

        // R11 enable gating
        wr(3, 32'h0);
        wr(0, 32'h9);
        wait_pend(4, "R3 start pending 3");
        chk("R11 irq masked", 32'(irq), 0);
        wr(3, 32'h10);
        chk("R11 irq unmasked", 32'(irq), 1);
        wr(4, 32'h10);
        wr(0, 32'h1);

        // R12 disable mid-burst
        base_rx = rx_cnt;
        load(4, 300, 1);
        wr(2, 32'd4);
        repeat (198) @(negedge clk);
        mon_off = 1'b1;
        wr(0, 32'h0);
        @(negedge clk);
        chk("R12 scl released", 32'(scl_oe), 0);
        chk("R12 sda released", 32'(sda_oe), 0);
        repeat (400) @(negedge clk);
        rd(4, v); chk("R12 no done after abort", v, 0);
        chk("R12 bytes before abort", rx_cnt - base_rx, 1);
        chk("R5 expected queue drained", exp_q.size(), 0);
        chk("R6 no extra start", starts, 4);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule